// File: doc/BRIEF.md
# Fuse Byte Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse array that offers random byte access. A client hands it a starting byte address and a byte count. The sequencer then drives the macro's control pins through a fixed, timed pattern. It puts the macro in read mode, and for each byte it places the address, pulses the strobe and captures the 8-bit data output. When the run is finished it parks the macro in a standby encoding.

Each captured byte leaves on a valid/ready stream. A consumer that stalls the stream also stalls the sequencer, so no byte is ever lost or overwritten. Every settle interval of one microsecond is counted in clock cycles. The parameter `CYC_PER_US` gives the number of cycles per microsecond, and a value below 1 is treated as 1.

The pin word has 16 bits: chip-select-bar (bit 0), strobe (bit 1), load (bit 2), program-enable-bar (bit 3), two unused zero bits (bits 4 and 5), and the 10-bit byte address (bits 15:6).

Top module: `fuse_rd_seq`

## Requirements
- R1: Out of reset and whenever idle, `fuse_ctrl` is 0x0009 (program-enable-bar and chip-select-bar high, all else low), `busy` and `out_valid` are low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle. `busy` is high from the cycle after acceptance until standby is reached. Request inputs presented while busy have no effect on `fuse_ctrl` or the stream.
- R3: For the `CYC_PER_US` cycles after acceptance, `fuse_ctrl` is 0x000C (load and program-enable-bar high, chip-select-bar, strobe and address low).
- R4: Each byte starts with one cycle of 0x000C (address field cleared). This is followed by `CYC_PER_US` cycles with the byte address in bits 15:6, load and program-enable-bar high and strobe low.
- R5: Strobe (bit 1) is then high for `CYC_PER_US` cycles with the address unchanged. `fuse_dout` is captured at the clock edge that ends the last strobe cycle, and it appears on `out_data` with `out_valid` high from the next cycle.
- R6: After the strobe, `fuse_ctrl` holds the address with strobe low for `CYC_PER_US` cycles before the next byte's clear cycle.
- R7: The byte address rises by one per byte and wraps from 1023 to 0.
- R8: A byte count of zero goes from the read-mode entry phase straight to standby, with `done`, and never raises `out_valid`.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` stays stable and `fuse_ctrl` stays at the post-strobe word. The next clear cycle, or standby, begins only on the edge after the byte is accepted.
- R10: `done` is high for exactly one cycle: the first standby cycle after a request, with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 10 | First byte address |
| req_len | input | 11 | Number of bytes to read |
| fuse_ctrl | output | 16 | Control pin word to the fuse macro |
| fuse_dout | input | 8 | Data output of the fuse macro |
| out_valid | output | 1 | Captured byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Captured byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that the macro's data output is valid by the last strobe-high cycle, and that the consumer treats the stream as a normal valid/ready channel. The bench models the macro combinationally from the driven pin word, so captured data depends only on the address presented during strobe. It sets the consumer-ready pattern each cycle away from the clock edge in several modes: always ready, pseudo-random, and held low for a long stretch. It also keeps offering conflicting requests during a busy transfer, to confirm they are ignored.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE,   // standby encoding on the pins
    ST_ENTRY,  // read mode entry settle
    ST_ACLR,   // address field cleared, one cycle
    ST_ASET,   // address placed, settle
    ST_STRB,   // strobe high
    ST_FALL,   // strobe low, settle
    ST_WOUT    // waiting for the consumer
  } seq_st_e;

  // Pin word layout (decoded by the fuse macro)
  localparam int CSB_BIT   = 0;
  localparam int STB_BIT   = 1;
  localparam int LOAD_BIT  = 2;
  localparam int PGENB_BIT = 3;
  localparam int ADDR_LSB  = 6;

endpackage

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
  parameter int CYC_PER_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CYC = (CYC_PER_US < 1) ? 1 : CYC_PER_US;
  localparam int CW  = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    if (!run || expired) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_q == '0);

endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              expired,
  input  logic              out_pending,
  output seq_st_e           st,
  output logic [ADDR_W-1:0] addr,
  output logic              timed,
  output logic              capture,
  output logic              req_ready,
  output logic              done
);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              done_q, done_d;
  logic              step;

  assign st        = st_q;
  assign addr      = addr_q;
  assign done      = done_q;
  assign req_ready = (st_q == ST_IDLE);
  assign timed     = (st_q == ST_ENTRY) || (st_q == ST_ASET) ||
                     (st_q == ST_STRB)  || (st_q == ST_FALL);

  // byte finished and handed over
  assign step = !out_pending &&
                (((st_q == ST_FALL) && expired) || (st_q == ST_WOUT));

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    left_d  = left_q;
    done_d  = 1'b0;
    capture = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d   = ST_ENTRY;
        addr_d = req_addr;
        left_d = req_len;
      end
      ST_ENTRY: if (expired) begin
        if (left_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_ACLR;
        end
      end
      ST_ACLR: st_d = ST_ASET;
      ST_ASET: if (expired) st_d = ST_STRB;
      ST_STRB: if (expired) begin
        st_d    = ST_FALL;
        capture = 1'b1;
      end
      ST_FALL: if (expired && out_pending) st_d = ST_WOUT;
      default: ;
    endcase
    if (step) begin
      left_d = left_q - LEN_W'(1);
      addr_d = addr_q + ADDR_W'(1);
      if (left_q == LEN_W'(1)) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        st_d = ST_ACLR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      done_q <= done_d;
    end
  end

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STRB || st_q == ST_FALL) |-> $stable(addr_q));

  // R8
  no_byte_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACLR) |-> left_q != '0);

endmodule

// File: rtl/fuse_rd_ctlenc.sv
module fuse_rd_ctlenc
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  seq_st_e                    st,
  input  logic [ADDR_W-1:0]          addr,
  output logic [ADDR_LSB+ADDR_W-1:0] ctrl
);

  always_comb begin
    ctrl = '0;
    if (st == ST_IDLE) begin
      ctrl[CSB_BIT]   = 1'b1;
      ctrl[PGENB_BIT] = 1'b1;
    end else begin
      ctrl[LOAD_BIT]  = 1'b1;
      ctrl[PGENB_BIT] = 1'b1;
      if (st != ST_ENTRY && st != ST_ACLR)
        ctrl[ADDR_LSB +: ADDR_W] = addr;
      if (st == ST_STRB)
        ctrl[STB_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/fuse_rd_outbuf.sv
module fuse_rd_outbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              pending
);

  logic              vld_d;
  logic [DATA_W-1:0] dat_d;
  logic              dat_en;

  assign pending = out_valid && !out_ready;
  assign dat_en  = capture;

  always_comb begin
    vld_d = out_valid;
    if (out_valid && out_ready) vld_d = 1'b0;
    if (capture)                vld_d = 1'b1;
    dat_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      if (dat_en) out_data <= dat_d;
    end
  end

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !out_valid);

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int ADDR_W     = 10,
  parameter int LEN_W      = 11,
  parameter int DATA_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [LEN_W-1:0]           req_len,
  output logic [ADDR_LSB+ADDR_W-1:0] fuse_ctrl,
  input  logic [DATA_W-1:0]          fuse_dout,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_data,
  output logic                       busy,
  output logic                       done
);

  localparam int CTRL_W = ADDR_LSB + ADDR_W;
  localparam logic [CTRL_W-1:0] W_STBY  =
    CTRL_W'((1 << CSB_BIT) | (1 << PGENB_BIT));
  localparam logic [CTRL_W-1:0] W_ENTRY =
    CTRL_W'((1 << LOAD_BIT) | (1 << PGENB_BIT));

  seq_st_e           st;
  logic [ADDR_W-1:0] addr;
  logic              timed, expired, capture, pending;

  fuse_rd_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timed),
    .expired (expired)
  );

  fuse_rd_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .expired     (expired),
    .out_pending (pending),
    .st          (st),
    .addr        (addr),
    .timed       (timed),
    .capture     (capture),
    .req_ready   (req_ready),
    .done        (done)
  );

  fuse_rd_ctlenc #(.ADDR_W(ADDR_W)) u_enc (
    .st   (st),
    .addr (addr),
    .ctrl (fuse_ctrl)
  );

  fuse_rd_outbuf #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .din       (fuse_dout),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pending   (pending)
  );

  assign busy = (st != ST_IDLE);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy && fuse_ctrl == W_STBY);

  // R3
  entry_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> fuse_ctrl == W_ENTRY);

  // R5
  strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctrl[STB_BIT] |-> $stable(fuse_ctrl[CTRL_W-1:ADDR_LSB]));

  // R6
  fall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_ctrl[STB_BIT]) |-> busy && $stable(fuse_ctrl[CTRL_W-1:ADDR_LSB]));

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  stall_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(fuse_ctrl) && !fuse_ctrl[STB_BIT]);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

endmodule

// File: tb/test_fuse_rd_seq.sv
module test_fuse_rd_seq;

  localparam int CLK_P = 10;
  localparam int CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [9:0]  req_addr;
  logic [10:0] req_len;
  logic [15:0] fuse_ctrl;
  logic [7:0]  fuse_dout;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;
  logic        busy, done;

  always #(CLK_P/2) clk = ~clk;

  fuse_rd_seq #(.CYC_PER_US(CYC)) i_fuse_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .fuse_ctrl(fuse_ctrl),
    .fuse_dout(fuse_dout), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .done(done)
  );

  function automatic logic [7:0] fval(input logic [9:0] a);
    logic [9:0] t;
    t = a * 10'd37 + 10'd11;
    return t[7:0] ^ {6'b0, a[9:8]};
  endfunction

  // fuse macro: data valid while strobe is high
  assign fuse_dout = fuse_ctrl[1] ? fval(fuse_ctrl[15:6]) : 8'h00;

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // reference model: expected pin word per cycle, held in a queue
  typedef struct {
    logic [15:0] w;
    bit          smp;
    bit          gate;
    logic [9:0]  a;
    string       rq;
  } item_t;

  item_t mq[$];
  bit         m_ov, m_done;
  logic [7:0] m_od;

  task automatic build(input logic [9:0] a0, input int len);
    item_t it;
    for (int k = 0; k < CYC; k++) begin
      it = '{16'h000C, 0, 0, 10'd0, (len == 0) ? "R8" : "R3"};
      mq.push_back(it);
    end
    for (int b = 0; b < len; b++) begin
      logic [9:0] a;
      a = a0 + 10'(b);
      it = '{16'h000C, 0, 0, a, "R4"};
      mq.push_back(it);
      for (int k = 0; k < CYC; k++) begin
        it = '{16'h000C | {a, 6'd0}, 0, 0, a, (b == 0) ? "R4" : "R7"};
        mq.push_back(it);
      end
      for (int k = 0; k < CYC; k++) begin
        it = '{16'h000E | {a, 6'd0}, (k == CYC-1), 0, a, "R5"};
        mq.push_back(it);
      end
      for (int k = 0; k < CYC; k++) begin
        it = '{16'h000C | {a, 6'd0}, 0, (k == CYC-1), a,
               (k == CYC-1) ? "R9" : "R6"};
        mq.push_back(it);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_ov = 0; m_done = 0; m_od = '0;
    end else begin
      bit pend, dn, smp;
      item_t it;
      pend = m_ov && !out_ready;
      dn = 0; smp = 0;
      if (m_ov && out_ready) m_ov = 0;
      if (mq.size() != 0) begin
        it = mq[0];
        if (!(it.gate && pend)) begin
          void'(mq.pop_front());
          smp = it.smp;
          if (mq.size() == 0) dn = 1;
        end
        if (smp) begin
          m_ov = 1;
          m_od = fval(it.a);
        end
      end else if (req_valid) begin
        build(req_addr, int'(req_len));
      end
      m_done = dn;
    end
  end

  // compare every cycle, then drive the consumer
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] ew;
      string rq;
      ew = (mq.size() != 0) ? mq[0].w : 16'h0009;
      rq = (mq.size() != 0) ? mq[0].rq : "R1";
      check(fuse_ctrl == ew, rq, "fuse_ctrl", fuse_ctrl, ew);
      check(busy == (mq.size() != 0), "R2", "busy", 16'(busy), 16'(mq.size() != 0));
      check(req_ready == (mq.size() == 0), "R2", "req_ready", 16'(req_ready),
            16'(mq.size() == 0));
      check(out_valid == m_ov, "R9", "out_valid", 16'(out_valid), 16'(m_ov));
      if (m_ov) check(out_data == m_od, "R5", "out_data", 16'(out_data), 16'(m_od));
      check(done == m_done, "R10", "done", 16'(done), 16'(m_done));
    end
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected at most 20000", cyc);
      finish_run();
    end
  end

  task automatic send(input logic [9:0] a, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 11'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fuse_ctrl == 16'h0009, "R1", "reset fuse_ctrl", fuse_ctrl, 16'h0009);
    check(!busy, "R1", "reset busy", 16'(busy), 16'h0);
    check(!out_valid, "R1", "reset out_valid", 16'(out_valid), 16'h0);
    check(req_ready, "R1", "reset req_ready", 16'(req_ready), 16'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6: plain run, consumer always ready
    rdy_mode = 0;
    send(10'd5, 3);
    wait_idle();

    // R8: zero length
    send(10'd100, 0);
    wait_idle();

    // R7 wrap with random backpressure
    rdy_mode = 1;
    send(10'd1022, 4);
    wait_idle();

    // R9: long stall on the first byte
    rdy_mode = 2;
    send(10'd300, 2);
    repeat (60) @(negedge clk);
    rdy_mode = 0;
    wait_idle();

    // R2: requests offered while busy are ignored
    send(10'd7, 2);
    req_valid = 1'b1; req_addr = 10'd900; req_len = 11'd9;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // longer run with random consumer
    rdy_mode = 1;
    send(10'd511, 6);
    wait_idle();

    finish_run();
  end

endmodule